// File: doc/BRIEF.md
# Interrupt Entry and Vectoring Unit

This unit sits next to a small processor core and decides, every clock cycle, whether the core must enter a reset, non-maskable (NMI) or maskable interrupt handler. It samples a reset-event request, an NMI request, six maskable request lines, the core's current program counter and its current status word. When an event is accepted, the unit registers the new program counter, the new status word, the matching save registers and the exception cause register at the next clock edge. It also pulses an entry strobe with a code for the kind of event.

An NMI that arrives while an earlier NMI handler is still running does not enter. Instead it is parked in a single pending flag. Any further NMIs that arrive during that time are dropped. A return-from-NMI pulse clears the in-progress flag, and a parked NMI then enters on the following cycle. The NMI path and the maskable path each have their own pair of save registers and their own half of the cause register, so one path's entry leaves the other path's saved context intact.

Top module: `irq_entry_unit`

## Requirements
- R1: Every accepted event pulses `entryValid` for the cycle after the request is sampled, with `entryKind` set to 1 for reset, 2 for NMI and 3 for maskable (0 when idle). In the new status word, bit 5 (interrupt disable) is set and bit 6 (exception pending) is clear.
- R2: A reset event drives the new PC to 0, the new status word to 0x20 and the cause register to 0. It also clears the NMI-in-progress flag and the pending-NMI flag.
- R3: An NMI with the in-progress flag clear has these effects. The current PC and status word are copied to the NMI save registers. The in-progress flag is set, and it is also shown as bit 7 of the new status word. The new PC becomes 0x10. The upper 16 bits of the cause register become 0x0010, and the lower 16 bits are unchanged.
- R4: An NMI request that arrives while the in-progress flag is set causes no entry and sets the pending flag. Later NMI requests in that state are dropped, so at most one parked NMI enters after the return.
- R5: A maskable entry copies the current PC and status word to the maskable save registers. It writes the vector code into the lower 16 bits of the cause register and leaves the upper 16 bits and the NMI save registers unchanged.
- R6: Maskable line i vectors to PC 0x80 + 0x10*i (0x80 up to 0xD0), and the lower cause field takes the same value.
- R7: Maskable requests are ignored while bit 5 of the current status word is set. NMI and reset events are accepted whatever that bit holds.
- R8: A pending NMI enters as soon as the in-progress flag is clear, and the pending flag clears at that entry. A return pulse clears the in-progress flag at the next edge, so the pending NMI enters one cycle later.
- R9: Priority is reset first, then NMI, then maskable lines with the lowest index first. An NMI that is parked does not block a maskable entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the unit's own registers |
| resetReq | input | 1 | Reset-event request |
| nmiReq | input | 1 | NMI request; each cycle it is high counts as one request |
| maskReq | input | 6 | Maskable request lines, index 0 has the highest priority |
| nmiReturn | input | 1 | Return-from-NMI pulse; clears the in-progress flag |
| curPc | input | 32 | Current program counter of the core |
| curPsw | input | 32 | Current status word of the core |
| entryValid | output | 1 | One-cycle strobe for an accepted event |
| entryKind | output | 2 | Event code: 0 none, 1 reset, 2 NMI, 3 maskable |
| newPc | output | 32 | Handler address to load |
| newPsw | output | 32 | Status word to load |
| nmiPcSave | output | 32 | PC saved on NMI entry |
| nmiPswSave | output | 32 | Status word saved on NMI entry |
| maskPcSave | output | 32 | PC saved on maskable entry |
| maskPswSave | output | 32 | Status word saved on maskable entry |
| causeReg | output | 32 | Cause register: upper half for NMI, lower half for maskable |
| nmiActive | output | 1 | NMI-in-progress flag |
| nmiPending | output | 1 | Parked-NMI flag |

## Verification
Several properties are checked on every cycle. Every entry sets the disable bit and clears the pending-exception bit. A reset event lands on its fixed values. An NMI in the in-progress state is parked rather than entered, and a parked NMI enters once the flag is clear. The disable bit suppresses maskable entry. A maskable vector always matches its cause code. Some behaviour can only be shown by the bench's ordered scenarios. These include exact vector selection under mixed request patterns, preservation of the other path's save registers and cause half, dropping of a third NMI, and the one-cycle delay between a return pulse and the parked entry.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_RESET = 2'd1,
    KIND_NMI   = 2'd2,
    KIND_MASK  = 2'd3
  } entryKind_e;

  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic doReset;
    logic doNmi;
    logic doMask;
  } entryStrobes_t;

endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int NUM_MASK = 6,
  localparam int IDX_W = (NUM_MASK > 1) ? $clog2(NUM_MASK) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                resetReq,
  input  logic                nmiReq,
  input  logic [NUM_MASK-1:0] maskReq,
  input  logic                nmiReturn,
  input  logic                idBit,
  output entryStrobes_t       strobes,
  output logic [IDX_W-1:0]    maskIdx,
  output logic                nmiActive,
  output logic                nmiPending
);

  logic activeQ, pendingQ;
  logic nmiWant, parkNmi;

  // lowest index wins
  always_comb begin
    maskIdx = '0;
    for (int i = NUM_MASK - 1; i >= 0; i--) begin
      if (maskReq[i]) maskIdx = IDX_W'(i);
    end
  end

  always_comb begin
    nmiWant         = nmiReq | pendingQ;
    strobes.doReset = resetReq;
    strobes.doNmi   = !resetReq && nmiWant && !activeQ;
    strobes.doMask  = !resetReq && !strobes.doNmi && !idBit && (|maskReq);
    parkNmi         = !resetReq && nmiReq && activeQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ  <= 1'b0;
      pendingQ <= 1'b0;
    end else if (strobes.doReset) begin
      activeQ  <= 1'b0;
      pendingQ <= 1'b0;
    end else if (strobes.doNmi) begin
      activeQ  <= 1'b1;
      pendingQ <= 1'b0;
    end else begin
      if (nmiReturn) activeQ  <= 1'b0;
      if (parkNmi)   pendingQ <= 1'b1;
    end
  end

  assign nmiActive  = activeQ;
  assign nmiPending = pendingQ;

endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_MASK    = 6,
  parameter int NMI_VECTOR  = 'h10,
  parameter int NMI_CODE    = 'h10,
  parameter int MASK_BASE   = 'h80,
  parameter int MASK_STEP   = 'h10,
  parameter int RESET_PSW   = 'h20,
  parameter int ID_BIT      = 5,
  parameter int EP_BIT      = 6,
  parameter int NP_BIT      = 7,
  localparam int IDX_W  = (NUM_MASK > 1) ? $clog2(NUM_MASK) : 1,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  entryStrobes_t     strobes,
  input  logic [IDX_W-1:0]  maskIdx,
  input  logic [DATA_W-1:0] curPc,
  input  logic [DATA_W-1:0] curPsw,
  output logic              entryValid,
  output logic [1:0]        entryKind,
  output logic [DATA_W-1:0] newPc,
  output logic [DATA_W-1:0] newPsw,
  output logic [DATA_W-1:0] nmiPcSave,
  output logic [DATA_W-1:0] nmiPswSave,
  output logic [DATA_W-1:0] maskPcSave,
  output logic [DATA_W-1:0] maskPswSave,
  output logic [DATA_W-1:0] causeReg
);

  logic [DATA_W-1:0] maskVec;
  logic [DATA_W-1:0] idMask, epMask, npMask;

  assign idMask  = DATA_W'(1) << ID_BIT;
  assign epMask  = DATA_W'(1) << EP_BIT;
  assign npMask  = DATA_W'(1) << NP_BIT;
  assign maskVec = DATA_W'(MASK_BASE) + DATA_W'(maskIdx) * DATA_W'(MASK_STEP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryValid  <= 1'b0;
      entryKind   <= KIND_NONE;
      newPc       <= '0;
      newPsw      <= '0;
      nmiPcSave   <= '0;
      nmiPswSave  <= '0;
      maskPcSave  <= '0;
      maskPswSave <= '0;
      causeReg    <= '0;
    end else begin
      entryValid <= strobes.doReset | strobes.doNmi | strobes.doMask;
      entryKind  <= KIND_NONE;
      if (strobes.doReset) begin
        entryKind <= KIND_RESET;
        newPc     <= '0;
        newPsw    <= DATA_W'(RESET_PSW);
        causeReg  <= '0;
      end else if (strobes.doNmi) begin
        entryKind  <= KIND_NMI;
        nmiPcSave  <= curPc;
        nmiPswSave <= curPsw;
        newPc      <= DATA_W'(NMI_VECTOR);
        newPsw     <= (curPsw | idMask | npMask) & ~epMask;
        causeReg[DATA_W-1:HALF_W] <= HALF_W'(NMI_CODE);
      end else if (strobes.doMask) begin
        entryKind   <= KIND_MASK;
        maskPcSave  <= curPc;
        maskPswSave <= curPsw;
        newPc       <= maskVec;
        newPsw      <= (curPsw | idMask) & ~epMask;
        causeReg[HALF_W-1:0] <= maskVec[HALF_W-1:0];
      end
    end
  end

endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
  import irq_entry_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_MASK   = 6,
  parameter int NMI_VECTOR = 'h10,
  parameter int NMI_CODE   = 'h10,
  parameter int MASK_BASE  = 'h80,
  parameter int MASK_STEP  = 'h10,
  parameter int RESET_PSW  = 'h20,
  parameter int ID_BIT     = 5,
  parameter int EP_BIT     = 6,
  parameter int NP_BIT     = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                resetReq,
  input  logic                nmiReq,
  input  logic [NUM_MASK-1:0] maskReq,
  input  logic                nmiReturn,
  input  logic [DATA_W-1:0]   curPc,
  input  logic [DATA_W-1:0]   curPsw,
  output logic                entryValid,
  output logic [1:0]          entryKind,
  output logic [DATA_W-1:0]   newPc,
  output logic [DATA_W-1:0]   newPsw,
  output logic [DATA_W-1:0]   nmiPcSave,
  output logic [DATA_W-1:0]   nmiPswSave,
  output logic [DATA_W-1:0]   maskPcSave,
  output logic [DATA_W-1:0]   maskPswSave,
  output logic [DATA_W-1:0]   causeReg,
  output logic                nmiActive,
  output logic                nmiPending
);

  localparam int IDX_W = (NUM_MASK > 1) ? $clog2(NUM_MASK) : 1;

  entryStrobes_t    strobes;
  logic [IDX_W-1:0] maskIdx;

  irq_entry_ctrl #(.NUM_MASK(NUM_MASK)) u_ctrl (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .nmiReq(nmiReq),
    .maskReq(maskReq), .nmiReturn(nmiReturn), .idBit(curPsw[ID_BIT]),
    .strobes(strobes), .maskIdx(maskIdx),
    .nmiActive(nmiActive), .nmiPending(nmiPending)
  );

  irq_entry_dp #(
    .DATA_W(DATA_W), .NUM_MASK(NUM_MASK), .NMI_VECTOR(NMI_VECTOR),
    .NMI_CODE(NMI_CODE), .MASK_BASE(MASK_BASE), .MASK_STEP(MASK_STEP),
    .RESET_PSW(RESET_PSW), .ID_BIT(ID_BIT), .EP_BIT(EP_BIT), .NP_BIT(NP_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .maskIdx(maskIdx),
    .curPc(curPc), .curPsw(curPsw),
    .entryValid(entryValid), .entryKind(entryKind),
    .newPc(newPc), .newPsw(newPsw),
    .nmiPcSave(nmiPcSave), .nmiPswSave(nmiPswSave),
    .maskPcSave(maskPcSave), .maskPswSave(maskPswSave),
    .causeReg(causeReg)
  );

endmodule

// File: rtl/irq_entry_checks.sv
module irq_entry_checks
  import irq_entry_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_MASK   = 6,
  parameter int NMI_VECTOR = 'h10,
  parameter int MASK_BASE  = 'h80,
  parameter int RESET_PSW  = 'h20,
  parameter int ID_BIT     = 5,
  parameter int EP_BIT     = 6,
  parameter int NP_BIT     = 7,
  localparam int HALF_W = DATA_W / 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                resetReq,
  input logic                nmiReq,
  input logic [NUM_MASK-1:0] maskReq,
  input logic [DATA_W-1:0]   curPsw,
  input logic                entryValid,
  input logic [1:0]          entryKind,
  input logic [DATA_W-1:0]   newPc,
  input logic [DATA_W-1:0]   newPsw,
  input logic [DATA_W-1:0]   causeReg,
  input logic                nmiActive,
  input logic                nmiPending
);

  // R1: entry status word has disable set, pending-exception clear
  a_r1_entry_psw: assert property (@(posedge clk) disable iff (!rstN)
    entryValid |-> (newPsw[ID_BIT] && !newPsw[EP_BIT] && entryKind != KIND_NONE));

  // R2: reset event lands on fixed values
  a_r2_reset_values: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> (newPc == '0 && newPsw == DATA_W'(RESET_PSW) && causeReg == '0
                  && !nmiActive && !nmiPending && entryKind == KIND_RESET));

  // R3: NMI entry state
  a_r3_nmi_entry: assert property (@(posedge clk) disable iff (!rstN)
    (entryValid && entryKind == KIND_NMI) |->
      (nmiActive && newPc == DATA_W'(NMI_VECTOR) && newPsw[NP_BIT]));

  // R4: NMI in progress parks the request
  a_r4_nmi_parked: assert property (@(posedge clk) disable iff (!rstN)
    (nmiReq && nmiActive && !resetReq) |=> (nmiPending && entryKind != KIND_NMI));

  // R6: maskable vector and cause code agree
  a_r6_mask_code: assert property (@(posedge clk) disable iff (!rstN)
    (entryValid && entryKind == KIND_MASK) |->
      (causeReg[HALF_W-1:0] == newPc[HALF_W-1:0] && newPc >= DATA_W'(MASK_BASE)));

  // R7: disable bit blocks maskable entry
  a_r7_id_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (curPsw[ID_BIT] && !resetReq && !nmiReq && !(nmiPending && !nmiActive))
      |=> !entryValid);

  // R8: parked NMI enters once the flag is clear
  a_r8_pending_enters: assert property (@(posedge clk) disable iff (!rstN)
    (nmiPending && !nmiActive && !resetReq) |=>
      (entryValid && entryKind == KIND_NMI && !nmiPending));

endmodule

bind irq_entry_unit irq_entry_checks #(
  .DATA_W(DATA_W), .NUM_MASK(NUM_MASK), .NMI_VECTOR(NMI_VECTOR),
  .MASK_BASE(MASK_BASE), .RESET_PSW(RESET_PSW),
  .ID_BIT(ID_BIT), .EP_BIT(EP_BIT), .NP_BIT(NP_BIT)
) u_checks (
  .clk(clk), .rstN(rstN), .resetReq(resetReq), .nmiReq(nmiReq),
  .maskReq(maskReq), .curPsw(curPsw), .entryValid(entryValid),
  .entryKind(entryKind), .newPc(newPc), .newPsw(newPsw),
  .causeReg(causeReg), .nmiActive(nmiActive), .nmiPending(nmiPending)
);

// File: tb/irq_entry_unit_bench.sv
module irq_entry_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  typedef struct packed {
    logic        rst;
    logic        nmi;
    logic [5:0]  mask;
    logic [31:0] psw;
    logic        ret;
    logic        expValid;
    logic [1:0]  expKind;
    logic [31:0] expPc;
    logic [7:0]  req;
  } vec_t;

  // rows run in order; NMI state carries from row to row
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 6'b000000, 32'h0,  1'b0, 1'b0, 2'd0, 32'h00, 8'd1},
    '{1'b0, 1'b0, 6'b000001, 32'h0,  1'b0, 1'b1, 2'd3, 32'h80, 8'd6},
    '{1'b0, 1'b0, 6'b100000, 32'h0,  1'b0, 1'b1, 2'd3, 32'hD0, 8'd6},
    '{1'b0, 1'b0, 6'b001100, 32'h0,  1'b0, 1'b1, 2'd3, 32'hA0, 8'd9},
    '{1'b0, 1'b0, 6'b001000, 32'h0,  1'b0, 1'b1, 2'd3, 32'hB0, 8'd6},
    '{1'b0, 1'b0, 6'b010000, 32'h0,  1'b0, 1'b1, 2'd3, 32'hC0, 8'd6},
    '{1'b0, 1'b0, 6'b000010, 32'h0,  1'b0, 1'b1, 2'd3, 32'h90, 8'd6},
    '{1'b0, 1'b0, 6'b111111, 32'h20, 1'b0, 1'b0, 2'd0, 32'h90, 8'd7},
    '{1'b1, 1'b1, 6'b111111, 32'h0,  1'b0, 1'b1, 2'd1, 32'h00, 8'd9},
    '{1'b0, 1'b1, 6'b000010, 32'h0,  1'b0, 1'b1, 2'd2, 32'h10, 8'd9},
    '{1'b0, 1'b0, 6'b000010, 32'h0,  1'b0, 1'b1, 2'd3, 32'h90, 8'd9},
    '{1'b0, 1'b1, 6'b000000, 32'h20, 1'b0, 1'b0, 2'd0, 32'h90, 8'd4},
    '{1'b0, 1'b1, 6'b000000, 32'h20, 1'b0, 1'b0, 2'd0, 32'h90, 8'd4},
    '{1'b0, 1'b0, 6'b000000, 32'h20, 1'b1, 1'b0, 2'd0, 32'h90, 8'd8},
    '{1'b0, 1'b0, 6'b000000, 32'h20, 1'b0, 1'b1, 2'd2, 32'h10, 8'd8},
    '{1'b0, 1'b0, 6'b000000, 32'h20, 1'b0, 1'b0, 2'd0, 32'h10, 8'd4},
    '{1'b0, 1'b0, 6'b000000, 32'h20, 1'b1, 1'b0, 2'd0, 32'h10, 8'd8},
    '{1'b0, 1'b0, 6'b000000, 32'h20, 1'b0, 1'b0, 2'd0, 32'h10, 8'd8},
    '{1'b0, 1'b1, 6'b000100, 32'h20, 1'b0, 1'b1, 2'd2, 32'h10, 8'd7},
    '{1'b0, 1'b1, 6'b000100, 32'h00, 1'b0, 1'b1, 2'd3, 32'hA0, 8'd9}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resetReq = 1'b0;
  logic        nmiReq = 1'b0;
  logic [5:0]  maskReq = '0;
  logic        nmiReturn = 1'b0;
  logic [31:0] curPc = '0;
  logic [31:0] curPsw = '0;
  logic        entryValid;
  logic [1:0]  entryKind;
  logic [31:0] newPc, newPsw, nmiPcSave, nmiPswSave;
  logic [31:0] maskPcSave, maskPswSave, causeReg;
  logic        nmiActive, nmiPending;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_entry_unit u_irq_entry_unit (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .nmiReq(nmiReq),
    .maskReq(maskReq), .nmiReturn(nmiReturn), .curPc(curPc), .curPsw(curPsw),
    .entryValid(entryValid), .entryKind(entryKind), .newPc(newPc),
    .newPsw(newPsw), .nmiPcSave(nmiPcSave), .nmiPswSave(nmiPswSave),
    .maskPcSave(maskPcSave), .maskPswSave(maskPswSave), .causeReg(causeReg),
    .nmiActive(nmiActive), .nmiPending(nmiPending)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // drive for one edge, then return at the next falling edge
  task automatic stepCycle(input logic rst, input logic nmi, input logic [5:0] mask,
                           input logic [31:0] pc, input logic [31:0] psw,
                           input logic ret);
    resetReq = rst; nmiReq = nmi; maskReq = mask;
    curPc = pc; curPsw = psw; nmiReturn = ret;
    @(posedge clk);
    @(negedge clk);
    resetReq = 1'b0; nmiReq = 1'b0; maskReq = '0; nmiReturn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    check("R1", "idle valid", 32'(entryValid), 32'h0);
    check("R1", "idle kind", 32'(entryKind), 32'h0);
    check("R2", "idle cause", causeReg, 32'h0);

    for (int i = 0; i < NV; i++) begin
      stepCycle(VECS[i].rst, VECS[i].nmi, VECS[i].mask, 32'h100 + 32'(i),
                VECS[i].psw, VECS[i].ret);
      check($sformatf("R%0d row%0d", VECS[i].req, i), "valid",
            32'(entryValid), 32'(VECS[i].expValid));
      check($sformatf("R%0d row%0d", VECS[i].req, i), "kind",
            32'(entryKind), 32'(VECS[i].expKind));
      check($sformatf("R%0d row%0d", VECS[i].req, i), "pc",
            newPc, VECS[i].expPc);
      if (VECS[i].expValid) begin
        check("R1", "psw id", 32'(newPsw[5]), 32'h1);
        check("R1", "psw ep", 32'(newPsw[6]), 32'h0);
      end
    end

    // directed: R2 clears flags
    stepCycle(1'b1, 1'b0, 6'b0, 32'h0, 32'h0, 1'b0);
    check("R2", "active after reset", 32'(nmiActive), 32'h0);
    check("R2", "cause after reset", causeReg, 32'h0);
    check("R2", "psw after reset", newPsw, 32'h20);

    // R5: maskable saves and lower cause, status with EP set on input
    stepCycle(1'b0, 1'b0, 6'b000010, 32'h1234, 32'h40, 1'b0);
    check("R5", "mask pc save", maskPcSave, 32'h1234);
    check("R5", "mask psw save", maskPswSave, 32'h40);
    check("R5", "new psw", newPsw, 32'h20);
    check("R5", "cause", causeReg, 32'h0000_0090);

    // R3: NMI saves, NP bit, upper cause, lower kept
    stepCycle(1'b0, 1'b1, 6'b0, 32'h5678, 32'h41, 1'b0);
    check("R3", "nmi pc save", nmiPcSave, 32'h5678);
    check("R3", "nmi psw save", nmiPswSave, 32'h41);
    check("R3", "new psw", newPsw, 32'hA1);
    check("R3", "cause", causeReg, 32'h0010_0090);
    check("R3", "active", 32'(nmiActive), 32'h1);
    check("R5", "mask save kept", maskPcSave, 32'h1234);

    // R9: parked NMI does not block maskable, R5 upper half kept
    stepCycle(1'b0, 1'b1, 6'b100000, 32'h9ABC, 32'h0, 1'b0);
    check("R9", "kind", 32'(entryKind), 32'h3);
    check("R4", "pending", 32'(nmiPending), 32'h1);
    check("R5", "cause upper kept", causeReg, 32'h0010_00D0);
    check("R5", "nmi save kept", nmiPcSave, 32'h5678);

    // R2: reset event drops the parked NMI
    stepCycle(1'b1, 1'b0, 6'b0, 32'h0, 32'h20, 1'b0);
    check("R2", "pending cleared", 32'(nmiPending), 32'h0);
    stepCycle(1'b0, 1'b0, 6'b0, 32'h0, 32'h20, 1'b0);
    check("R2", "no parked entry", 32'(entryValid), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule